// File: doc/BRIEF.md
# Tagged Capability Memory

This block is a single-port synchronous memory in which every 128-bit granule carries one hidden validity tag. The tag has no address of its own: it can only be set by a capability store of a full, aligned granule whose source tag is valid, and it is lost silently whenever an ordinary data write touches any byte of that granule. Loads return the granule data together with its tag, so a processor can tell a genuine capability from bytes that merely look like one.

The memory is split into pages, and each page holds one capability-dirty bit. The bit is set when a tagged capability lands anywhere in the page. A second, independent port reads and clears a page's bit in one step. A revocation sweeper can use it to visit only pages that may hold capabilities, and then clear them for the next pass. Requests take one cycle. Responses come from registers on the following cycle.

Top module: `tagged_mem`

## Requirements
- R1: After synchronous reset, rsp_valid and pg_rsp_valid are 0, every granule tag reads 0 and every page dirty bit reads 0. Granule data is not reset.
- R2: A load (req_op 2'b00) yields rsp_valid=1 on the next cycle, with the granule's 128 data bits on rsp_rdata and its tag on rsp_tag. The granule is addressed by req_addr bits above bit 3.
- R3: A capability store (req_op 2'b10) to an address with req_addr[3:0]=0 writes all 16 bytes and sets the granule tag to req_tag_in.
- R4: A data write (req_op 2'b01) writes only the bytes whose req_be bit is set (bit i selects rsp_rdata bits 8i+7:8i). It clears the granule's tag when any enable is set, even if the written bytes equal the old ones.
- R5: A data write with req_be all zero leaves the data and the tag unchanged.
- R6: A capability store with req_addr[3:0] not zero sets rsp_err=1 on its response. It changes no data, tag or dirty bit. rsp_err is 1 only in that case.
- R7: A capability store with req_tag_in=0 writes the data, clears the tag and does not set the page dirty bit.
- R8: A capability store with req_tag_in=1 sets the dirty bit of page req_addr[ADDR_W-1:PAGE_BITS] and no other page's bit.
- R9: pg_req=1 yields pg_rsp_valid=1 on the next cycle, with pg_rsp_dirty holding the bit's value before the request, and clears the bit.
- R10: If a tagged capability store and a page read-and-clear name the same page in the same cycle, the response shows the old value and the bit ends up set.
- R11: req_op 2'b11, or req_valid=0, changes nothing and gives rsp_valid=0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 00 load, 01 data write, 10 capability store, 11 no operation |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | 16 | Byte enables for data writes |
| req_wdata | input | 128 | Write data |
| req_tag_in | input | 1 | Source tag for capability stores |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Misaligned capability store |
| rsp_rdata | output | 128 | Load data |
| rsp_tag | output | 1 | Load tag |
| pg_req | input | 1 | Page dirty read-and-clear strobe |
| pg_idx | input | ADDR_W-PAGE_BITS | Page index |
| pg_rsp_valid | output | 1 | Page response strobe |
| pg_rsp_dirty | output | 1 | Page dirty value before the clear |

## Verification
The hardest case to reach is a tagged store and a read-and-clear that hit the same page in the same cycle. The bench drives both ports on one clock edge and then reads the page a second time to show the set won. The other hard case is a failed store leaving state alone. A misaligned tagged store goes to a page that has no tagged stores, and then a load and a page read show that nothing moved. Tag loss on a write that leaves the data the same is shown by rewriting bytes with their existing values and loading the tag back.

// File: rtl/tmem_pkg.sv
package tmem_pkg;
  localparam int GRAN_BYTES = 16;
  localparam int GRAN_BITS  = GRAN_BYTES * 8;
  localparam int GOFF_W     = $clog2(GRAN_BYTES);

  typedef enum logic [1:0] {
    OP_LOAD   = 2'b00,
    OP_DWRITE = 2'b01,
    OP_CSTORE = 2'b10,
    OP_NONE   = 2'b11
  } tmem_op_e;
endpackage

// File: rtl/tmem_data_ram.sv
module tmem_data_ram #(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6,
  parameter int LANES = 16
) (
  input  logic               clk,
  input  logic               we,
  input  logic [IDX_W-1:0]   idx,
  input  logic [LANES-1:0]   be,
  input  logic [LANES*8-1:0] wdata,
  output logic [LANES*8-1:0] rdata
);
  // One RAM per byte lane. Each lane has read-first behaviour, so it maps onto block RAM.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (we && be[g]) lane_mem[idx] <= wdata[g*8 +: 8];
      lane_q <= lane_mem[idx];
    end
    assign rdata[g*8 +: 8] = lane_q;
  end
endmodule

// File: rtl/tmem_tag_store.sv
module tmem_tag_store #(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             wr_en,
  input  logic             wr_val,
  output logic             rd_tag
);
  logic [DEPTH-1:0] tags;

  always_ff @(posedge clk) begin
    if (rst) begin
      tags   <= '0;
      rd_tag <= 1'b0;
    end else begin
      rd_tag <= tags[idx];
      if (wr_en) tags[idx] <= wr_val;
    end
  end
endmodule

// File: rtl/tmem_page_dirty.sv
module tmem_page_dirty #(
  parameter int PAGES = 16,
  parameter int PG_W  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_en,
  input  logic [PG_W-1:0] set_idx,
  input  logic            clr_req,
  input  logic [PG_W-1:0] clr_idx,
  output logic            rsp_valid,
  output logic            rsp_dirty
);
  logic [PAGES-1:0] bits_q, bits_d;

  // The clear is applied first and the set second, so a store in the same cycle wins.
  always_comb begin
    bits_d = bits_q;
    if (clr_req) bits_d[clr_idx] = 1'b0;
    if (set_en)  bits_d[set_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_dirty <= 1'b0;
    end else begin
      bits_q    <= bits_d;
      rsp_valid <= clr_req;
      if (clr_req) rsp_dirty <= bits_q[clr_idx];
    end
  end
endmodule

// File: rtl/tagged_mem.sv
module tagged_mem
  import tmem_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int PAGE_BITS = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [1:0]              req_op,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [GRAN_BYTES-1:0]   req_be,
  input  logic [GRAN_BITS-1:0]    req_wdata,
  input  logic                    req_tag_in,
  output logic                    rsp_valid,
  output logic                    rsp_err,
  output logic [GRAN_BITS-1:0]    rsp_rdata,
  output logic                    rsp_tag,
  input  logic                    pg_req,
  input  logic [ADDR_W-PAGE_BITS-1:0] pg_idx,
  output logic                    pg_rsp_valid,
  output logic                    pg_rsp_dirty
);
  localparam int GIDX_W = ADDR_W - GOFF_W;
  localparam int GRANS  = 1 << GIDX_W;
  localparam int PG_W   = ADDR_W - PAGE_BITS;
  localparam int PAGES  = 1 << PG_W;

  tmem_op_e          op;
  logic [GIDX_W-1:0] gidx;
  logic [PG_W-1:0]   pidx;
  logic              do_load, do_dwr, do_cap, cap_ok, cap_bad, dwr_any;
  logic              ram_we, tag_we, tag_val, dirty_set;
  logic [GRAN_BYTES-1:0] ram_be;

  assign op   = tmem_op_e'(req_op);
  assign gidx = req_addr[ADDR_W-1:GOFF_W];
  assign pidx = req_addr[ADDR_W-1:PAGE_BITS];

  always_comb begin
    do_load   = req_valid && (op == OP_LOAD);
    do_dwr    = req_valid && (op == OP_DWRITE);
    do_cap    = req_valid && (op == OP_CSTORE);
    cap_ok    = do_cap && (req_addr[GOFF_W-1:0] == '0);
    cap_bad   = do_cap && !cap_ok;
    dwr_any   = do_dwr && (|req_be);
    ram_we    = dwr_any || cap_ok;
    ram_be    = cap_ok ? '1 : req_be;
    tag_we    = dwr_any || cap_ok;
    tag_val   = cap_ok && req_tag_in;
    dirty_set = cap_ok && req_tag_in;
  end

  tmem_data_ram #(.DEPTH(GRANS), .IDX_W(GIDX_W), .LANES(GRAN_BYTES)) ram_i (
    .clk(clk), .we(ram_we), .idx(gidx), .be(ram_be),
    .wdata(req_wdata), .rdata(rsp_rdata)
  );

  tmem_tag_store #(.DEPTH(GRANS), .IDX_W(GIDX_W)) tag_i (
    .clk(clk), .rst(rst), .idx(gidx), .wr_en(tag_we),
    .wr_val(tag_val), .rd_tag(rsp_tag)
  );

  tmem_page_dirty #(.PAGES(PAGES), .PG_W(PG_W)) dirty_i (
    .clk(clk), .rst(rst), .set_en(dirty_set), .set_idx(pidx),
    .clr_req(pg_req), .clr_idx(pg_idx),
    .rsp_valid(pg_rsp_valid), .rsp_dirty(pg_rsp_dirty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= do_load || do_dwr || do_cap;
      rsp_err   <= cap_bad;
    end
  end
endmodule

// File: rtl/tagged_mem_chk.sv
module tagged_mem_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              pg_req,
  input logic              pg_rsp_valid
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!rsp_valid && !pg_rsp_valid));

  p_ack_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op != 2'b11) |=> rsp_valid);

  p_noop_silent_r11: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_op != 2'b11) |=> !rsp_valid);

  p_misalign_err_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 2'b10 && req_addr[3:0] != 4'd0) |=> rsp_err);

  p_err_source_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> $past(req_valid && req_op == 2'b10 && req_addr[3:0] != 4'd0));

  p_page_ack_r9: assert property (@(posedge clk) disable iff (rst)
    pg_req |=> pg_rsp_valid);
endmodule

bind tagged_mem tagged_mem_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .pg_req(pg_req), .pg_rsp_valid(pg_rsp_valid)
);

// File: tb/tagged_mem_tb_top.sv
module tagged_mem_tb_top;
  localparam int AW = 10;
  localparam int PB = 6;

  logic         clk = 1'b0;
  logic         rst;
  logic         req_valid;
  logic [1:0]   req_op;
  logic [AW-1:0] req_addr;
  logic [15:0]  req_be;
  logic [127:0] req_wdata;
  logic         req_tag_in;
  logic         rsp_valid, rsp_err, rsp_tag;
  logic [127:0] rsp_rdata;
  logic         pg_req;
  logic [AW-PB-1:0] pg_idx;
  logic         pg_rsp_valid, pg_rsp_dirty;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tagged_mem #(.ADDR_W(AW), .PAGE_BITS(PB)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .req_tag_in(req_tag_in), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .rsp_tag(rsp_tag), .pg_req(pg_req),
    .pg_idx(pg_idx), .pg_rsp_valid(pg_rsp_valid), .pg_rsp_dirty(pg_rsp_dirty)
  );

  typedef struct packed {
    logic [1:0]   op;
    logic [9:0]   addr;
    logic [15:0]  be;
    logic [127:0] wd;
    logic         tin;
    logic         ev;
    logic         ee;
    logic         cd;
    logic [127:0] ed;
    logic         et;
    logic [3:0]   rq;
  } vec_t;

  localparam logic [127:0] DA  = 128'h0123456789ABCDEF_FEDCBA9876543210;
  localparam logic [127:0] DB  = {4{32'hB0B0CAFE}};
  localparam logic [127:0] DC  = {4{32'hC3C3C3C3}};
  localparam logic [127:0] DD  = {16{8'h11}};
  localparam logic [127:0] DE  = {16{8'hEE}};
  localparam logic [127:0] DDE = {{12{8'h11}}, {4{8'hEE}}};
  localparam logic [127:0] DAX = DA;

  localparam int NV = 13;
  localparam vec_t VT [NV] = '{
    '{2'b10, 10'h000, 16'h0000, DA, 1'b1, 1'b1, 1'b0, 1'b0, '0, 1'b0, 4'd3},  // R3 tagged store
    '{2'b00, 10'h000, 16'h0000, '0, 1'b0, 1'b1, 1'b0, 1'b1, DA, 1'b1, 4'd2},  // R2 / R3 load back
    '{2'b01, 10'h000, 16'h0000, DE, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, 4'd5},  // R5 empty write
    '{2'b00, 10'h000, 16'h0000, '0, 1'b0, 1'b1, 1'b0, 1'b1, DA, 1'b1, 4'd5},  // R5 nothing changed
    '{2'b01, 10'h000, 16'h00F0, DAX, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, 4'd4}, // R4 same bytes rewritten
    '{2'b00, 10'h000, 16'h0000, '0, 1'b0, 1'b1, 1'b0, 1'b1, DA, 1'b0, 4'd4},  // R4 tag gone
    '{2'b10, 10'h040, 16'h0000, DB, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, 4'd7},  // R7 untagged store
    '{2'b00, 10'h040, 16'h0000, '0, 1'b0, 1'b1, 1'b0, 1'b1, DB, 1'b0, 4'd7},  // R7 data, no tag
    '{2'b10, 10'h048, 16'h0000, DC, 1'b1, 1'b1, 1'b1, 1'b0, '0, 1'b0, 4'd6},  // R6 misaligned
    '{2'b00, 10'h040, 16'h0000, '0, 1'b0, 1'b1, 1'b0, 1'b1, DB, 1'b0, 4'd6},  // R6 unchanged
    '{2'b01, 10'h080, 16'hFFFF, DD, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, 4'd4},  // R4 full write
    '{2'b01, 10'h080, 16'h000F, DE, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, 4'd4},  // R4 partial write
    '{2'b11, 10'h080, 16'hFFFF, DC, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0, 4'd11}  // R11 no-op
  };

  task automatic fail(string req, string what, logic [127:0] act, logic [127:0] exp);
    errors++;
    $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
  endtask

  task automatic idle();
    req_valid = 1'b0; req_op = 2'b00; req_addr = '0; req_be = '0;
    req_wdata = '0; req_tag_in = 1'b0; pg_req = 1'b0; pg_idx = '0;
  endtask

  task automatic issue(vec_t v);
    @(negedge clk);
    req_valid = 1'b1; req_op = v.op; req_addr = v.addr; req_be = v.be;
    req_wdata = v.wd; req_tag_in = v.tin;
    @(negedge clk);
    idle();
  endtask

  task automatic load_chk(logic [9:0] a, logic [127:0] ed, logic chk_d, logic et, string req);
    vec_t v;
    v = '0; v.op = 2'b00; v.addr = a;
    issue(v);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_tag !== et || (chk_d && rsp_rdata !== ed))
      fail(req, "load v/tag/data", {rsp_valid, rsp_tag, rsp_rdata[125:0]}, {1'b1, et, ed[125:0]});
  endtask

  task automatic page_chk(logic [3:0] p, logic exp, string req);
    @(negedge clk);
    pg_req = 1'b1; pg_idx = p;
    @(negedge clk);
    idle();
    checks++;
    if (pg_rsp_valid !== 1'b1 || pg_rsp_dirty !== exp)
      fail(req, "page dirty", {pg_rsp_valid, pg_rsp_dirty}, {1'b1, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t v;
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: quiet outputs and clean tag/dirty state after reset
    checks++;
    if (rsp_valid !== 1'b0 || pg_rsp_valid !== 1'b0)
      fail("R1", "outputs after reset", {rsp_valid, pg_rsp_valid}, 0);
    load_chk(10'h000, '0, 1'b0, 1'b0, "R1");
    page_chk(4'd0, 1'b0, "R1");

    for (int i = 0; i < NV; i++) begin
      issue(VT[i]);
      checks++;
      if (rsp_valid !== VT[i].ev || rsp_err !== VT[i].ee ||
          (VT[i].cd && (rsp_rdata !== VT[i].ed || rsp_tag !== VT[i].et)))
        fail($sformatf("R%0d", VT[i].rq), $sformatf("vector %0d", i),
             {rsp_valid, rsp_err, rsp_tag, rsp_rdata[124:0]},
             {VT[i].ev, VT[i].ee, VT[i].et, VT[i].ed[124:0]});
    end

    // R4: partial write merged bytes; R11: no-op left granule as is
    load_chk(10'h080, DDE, 1'b1, 1'b0, "R4");

    // R8: page 0 got a tagged store; R9: clear then reads 0
    page_chk(4'd0, 1'b1, "R8");
    page_chk(4'd0, 1'b0, "R9");
    // R7 / R6: page 1 saw only an untagged store and a rejected one
    page_chk(4'd1, 1'b0, "R7");
    page_chk(4'd2, 1'b0, "R8");

    // R10: store and read-and-clear to page 3 in the same cycle
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'b10; req_addr = 10'h0C0; req_wdata = DC; req_tag_in = 1'b1;
    pg_req = 1'b1; pg_idx = 4'd3;
    @(negedge clk);
    idle();
    checks++;
    if (pg_rsp_valid !== 1'b1 || pg_rsp_dirty !== 1'b0)
      fail("R10", "same-cycle old value", {pg_rsp_valid, pg_rsp_dirty}, 2'b10);
    page_chk(4'd3, 1'b1, "R10");

    // R1: reset wipes a fresh tag and dirty bit
    v = '0; v.op = 2'b10; v.addr = 10'h100; v.wd = DA; v.tin = 1'b1;
    issue(v);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    load_chk(10'h100, DA, 1'b1, 1'b0, "R1");
    page_chk(4'd4, 1'b0, "R1");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule